// File: doc/BRIEF.md
# Multi-Form Instruction Decoder

This block turns one instruction of a 16-bit processor into the control fields that the ALU and the register file need. An instruction is either one halfword (short) or two halfwords (long). Each length has two addressing forms. A short instruction names two registers, or one register and a signed 4-bit constant that takes the source register's place. A long instruction names two registers and carries a 16-bit immediate, or it names three registers with a separate destination. The first halfword always holds the opcode, which is a 2-bit group and a 3-bit function. The second halfword of a long instruction arrives on its own input.

The fetch stage presents the first halfword with `i_hw0_valid` and, for a long instruction, the second halfword with `i_hw1_valid` in the same cycle. One clock later the decoder drives a registered set of fields and raises `o_valid`. The register-file and ALU stages take those fields without further decoding. Fetch buffering, hazards and execution belong to other blocks.

Top module: `multiform_decoder`

## Requirements
- R1: While reset is asserted and at the first edge after it, `o_valid` and every field output are 0.
- R2: Bit 0 of the first halfword marks a long instruction (1 = 32-bit, 0 = 16-bit), and `o_long` reports it.
- R3: Bit 1 of the first halfword selects the form within a length. `o_form` = {bit 0, bit 1}: 0 = short reg-reg, 1 = short reg-imm4, 2 = long reg-reg-imm16, 3 = long three-register.
- R4: `o_group` is bits 6:5 and `o_func` is bits 4:2 of the first halfword.
- R5: `o_rt` is bits 15:12 and `o_rs` is bits 11:8 of the first halfword in every form. In every form except the three-register form, `o_rd` equals `o_rt`. In short reg-reg form, `o_use_imm` is 0 and `o_imm` is 0.
- R6: In short reg-imm4 form, `o_use_imm` is 1 and `o_imm` is bits 11:8 sign-extended to 16 bits, which covers -8 to +7.
- R7: In long reg-reg-imm16 form, `o_use_imm` is 1 and `o_imm` equals the second halfword.
- R8: In the three-register form, `o_rd` is bits 15:12 of the second halfword, `o_use_imm` is 0, `o_imm` is 0, and bits 11:0 of the second halfword have no effect.
- R9: `o_valid` rises one cycle after `i_hw0_valid` for a short instruction, whatever `i_hw1_valid` is. A long instruction also needs `i_hw1_valid` in the same cycle, or `o_valid` stays 0.
- R10: Every field output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_hw0_valid | input | 1 | First halfword present |
| i_hw0 | input | 16 | First halfword (opcode, form, registers) |
| i_hw1_valid | input | 1 | Second halfword present |
| i_hw1 | input | 16 | Second halfword of a long instruction |
| o_valid | output | 1 | Decoded instruction complete |
| o_long | output | 1 | Instruction is 32 bits |
| o_form | output | 2 | Addressing form code |
| o_group | output | 2 | ALU group |
| o_func | output | 3 | ALU function within the group |
| o_rs | output | 4 | Source register field |
| o_rt | output | 4 | Second operand register field |
| o_rd | output | 4 | Destination register |
| o_use_imm | output | 1 | ALU takes the immediate instead of `o_rs` |
| o_imm | output | 16 | Immediate, sign-extended when short |

## Verification
The decoded result is due exactly one rising edge after its inputs are presented. The bench drives new inputs on the falling edge. At the next falling edge it compares every output with a model value it computed when it drove the inputs. Fields are compared only when that model expects `o_valid`, and `o_valid` itself is compared on every cycle. This exposes a long instruction that decodes without its second halfword, and a short instruction that waits for one.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
   typedef enum logic [1:0] {
      FORM_SRR  = 2'd0,
      FORM_SRI4 = 2'd1,
      FORM_LRRI = 2'd2,
      FORM_LRRR = 2'd3
   } mfd_form_e;

   localparam int LEN_BIT  = 0;
   localparam int FSEL_BIT = 1;
   localparam int OPC_LSB  = 2;
endpackage

// File: rtl/mfd_form.sv
module mfd_form
   import mfd_pkg::*;
(
   input  logic      len_bit,
   input  logic      fsel_bit,
   input  logic      hw0_valid,
   input  logic      hw1_valid,
   output logic      is_long,
   output mfd_form_e form,
   output logic      complete
);
   assign is_long  = len_bit;
   assign form     = mfd_form_e'({len_bit, fsel_bit});
   assign complete = hw0_valid & (~len_bit | hw1_valid);
endmodule

// File: rtl/mfd_fields.sv
module mfd_fields
   import mfd_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int REG_W  = 4,
   parameter int GRP_W  = 2,
   parameter int FN_W   = 3
) (
   input  logic [DATA_W-1:0] hw0,
   output logic [GRP_W-1:0]  group,
   output logic [FN_W-1:0]   func,
   output logic [REG_W-1:0]  rs,
   output logic [REG_W-1:0]  rt
);
   localparam int FN_LSB  = OPC_LSB;
   localparam int GRP_LSB = FN_LSB + FN_W;
   localparam int RS_LSB  = DATA_W - 2*REG_W;
   localparam int RT_LSB  = DATA_W - REG_W;

   logic unused_hw0;
   assign unused_hw0 = ^hw0;

   assign func  = hw0[FN_LSB  +: FN_W];
   assign group = hw0[GRP_LSB +: GRP_W];
   assign rs    = hw0[RS_LSB  +: REG_W];
   assign rt    = hw0[RT_LSB  +: REG_W];
endmodule

// File: rtl/mfd_operand.sv
module mfd_operand
   import mfd_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int REG_W  = 4
) (
   input  mfd_form_e         form,
   input  logic [REG_W-1:0]  rt,
   input  logic [REG_W-1:0]  nib,
   input  logic [DATA_W-1:0] hw1,
   output logic [REG_W-1:0]  rd,
   output logic              use_imm,
   output logic [DATA_W-1:0] imm
);
   localparam int EXT_W = DATA_W - REG_W;

   logic [DATA_W-1:0] short_imm;
   assign short_imm = {{EXT_W{nib[REG_W-1]}}, nib};

   always_comb begin
      rd      = rt;
      use_imm = 1'b0;
      imm     = '0;
      unique case (form)
         FORM_SRI4: begin
            use_imm = 1'b1;
            imm     = short_imm;
         end
         FORM_LRRI: begin
            use_imm = 1'b1;
            imm     = hw1;
         end
         FORM_LRRR: rd = hw1[DATA_W-1 -: REG_W];
         default: ;
      endcase
   end
endmodule

// File: rtl/multiform_decoder.sv
module multiform_decoder
   import mfd_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int REG_W   = 4,
   parameter int GRP_W   = 2,
   parameter int FN_W    = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_hw0_valid,
   input  logic [DATA_W-1:0] i_hw0,
   input  logic              i_hw1_valid,
   input  logic [DATA_W-1:0] i_hw1,
   output logic              o_valid,
   output logic              o_long,
   output logic [1:0]        o_form,
   output logic [GRP_W-1:0]  o_group,
   output logic [FN_W-1:0]   o_func,
   output logic [REG_W-1:0]  o_rs,
   output logic [REG_W-1:0]  o_rt,
   output logic [REG_W-1:0]  o_rd,
   output logic              o_use_imm,
   output logic [DATA_W-1:0] o_imm
);
   localparam int HDR_W = OPC_LSB + FN_W + GRP_W;
   localparam int BUS_W = 2 + 2 + GRP_W + FN_W + 3*REG_W + 1 + DATA_W;

   if (HDR_W + 2*REG_W > DATA_W) begin : g_fit_chk
      $error("opcode and register fields do not fit the halfword");
   end
   if (REG_W < 2) begin : g_reg_chk
      $error("register field too narrow for a signed short constant");
   end

   logic              d_long, d_ok, d_use_imm;
   mfd_form_e         d_form;
   logic [GRP_W-1:0]  d_group;
   logic [FN_W-1:0]   d_func;
   logic [REG_W-1:0]  d_rs, d_rt, d_rd;
   logic [DATA_W-1:0] d_imm;

   mfd_form u_form (
      .len_bit   (i_hw0[LEN_BIT]),
      .fsel_bit  (i_hw0[FSEL_BIT]),
      .hw0_valid (i_hw0_valid),
      .hw1_valid (i_hw1_valid),
      .is_long   (d_long),
      .form      (d_form),
      .complete  (d_ok)
   );

   mfd_fields #(.DATA_W(DATA_W), .REG_W(REG_W), .GRP_W(GRP_W), .FN_W(FN_W)) u_fields (
      .hw0   (i_hw0),
      .group (d_group),
      .func  (d_func),
      .rs    (d_rs),
      .rt    (d_rt)
   );

   mfd_operand #(.DATA_W(DATA_W), .REG_W(REG_W)) u_operand (
      .form    (d_form),
      .rt      (d_rt),
      .nib     (d_rs),
      .hw1     (i_hw1),
      .rd      (d_rd),
      .use_imm (d_use_imm),
      .imm     (d_imm)
   );

   logic [BUS_W-1:0] dec_bus, out_bus;
   assign dec_bus = {d_ok, d_long, d_form, d_group, d_func, d_rs, d_rt, d_rd, d_use_imm, d_imm};

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) out_bus <= '0;
         else        out_bus <= dec_bus;
      end
   end else begin : g_comb_out
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_bus    = dec_bus;
   end

   assign {o_valid, o_long, o_form, o_group, o_func, o_rs, o_rt, o_rd, o_use_imm, o_imm} = out_bus;
endmodule

// File: rtl/mfd_checker.sv
module mfd_checker #(
   parameter int DATA_W  = 16,
   parameter int REG_W   = 4,
   parameter int GRP_W   = 2,
   parameter int FN_W    = 3,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              i_hw0_valid,
   input logic [DATA_W-1:0] i_hw0,
   input logic              i_hw1_valid,
   input logic [DATA_W-1:0] i_hw1,
   input logic              o_valid,
   input logic [1:0]        o_form,
   input logic [GRP_W-1:0]  o_group,
   input logic [REG_W-1:0]  o_rt,
   input logic [REG_W-1:0]  o_rd,
   input logic              o_use_imm,
   input logic [DATA_W-1:0] o_imm
);
   localparam int GRP_LSB = 2 + FN_W;

   a_r5_two_operand_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_form != 2'd3) |-> (o_rd == o_rt));

   a_r6_imm4_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_form == 2'd1) |->
         (o_use_imm && (o_imm[DATA_W-1:REG_W-1] == '0 || o_imm[DATA_W-1:REG_W-1] == '1)));

   if (OUT_REG) begin : g_seq
      a_r9_short_valid: assert property (@(posedge clk) disable iff (!rst_n)
         (i_hw0_valid && !i_hw0[0]) |=> o_valid);

      a_r9_long_wait: assert property (@(posedge clk) disable iff (!rst_n)
         (i_hw0_valid && i_hw0[0] && !i_hw1_valid) |=> !o_valid);

      a_r4_group: assert property (@(posedge clk) disable iff (!rst_n)
         i_hw0_valid |=> (!o_valid || o_group == $past(i_hw0[GRP_LSB +: GRP_W])));

      a_r7_imm16: assert property (@(posedge clk) disable iff (!rst_n)
         (i_hw0_valid && i_hw0[0] && !i_hw0[1] && i_hw1_valid) |=>
            (o_use_imm && o_imm == $past(i_hw1)));

      a_r8_third_reg: assert property (@(posedge clk) disable iff (!rst_n)
         (i_hw0_valid && i_hw0[0] && i_hw0[1] && i_hw1_valid) |=>
            (!o_use_imm && o_rd == $past(i_hw1[DATA_W-1 -: REG_W])));
   end
endmodule

bind multiform_decoder mfd_checker #(
   .DATA_W(DATA_W), .REG_W(REG_W), .GRP_W(GRP_W), .FN_W(FN_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .i_hw0_valid (i_hw0_valid),
   .i_hw0       (i_hw0),
   .i_hw1_valid (i_hw1_valid),
   .i_hw1       (i_hw1),
   .o_valid     (o_valid),
   .o_form      (o_form),
   .o_group     (o_group),
   .o_rt        (o_rt),
   .o_rd        (o_rd),
   .o_use_imm   (o_use_imm),
   .o_imm       (o_imm)
);

// File: tb/multiform_decoder_tb.sv
module multiform_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw0_v = 1'b0, hw1_v = 1'b0;
   logic [15:0] hw0 = '0, hw1 = '0;
   logic        o_valid, o_long, o_use_imm;
   logic [1:0]  o_form, o_group;
   logic [2:0]  o_func;
   logic [3:0]  o_rs, o_rt, o_rd;
   logic [15:0] o_imm;

   int checks = 0, failures = 0;
   bit done = 0;

   int e_valid, e_long, e_form, e_group, e_func, e_rs, e_rt, e_rd, e_use, e_imm;

   always #5 clk = ~clk;

   multiform_decoder u_dut (
      .clk(clk), .rst_n(rst_n),
      .i_hw0_valid(hw0_v), .i_hw0(hw0), .i_hw1_valid(hw1_v), .i_hw1(hw1),
      .o_valid(o_valid), .o_long(o_long), .o_form(o_form), .o_group(o_group),
      .o_func(o_func), .o_rs(o_rs), .o_rt(o_rt), .o_rd(o_rd),
      .o_use_imm(o_use_imm), .o_imm(o_imm)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(int rt, int rs, int grp, int fn, int fsel, int lng);
      return 16'(rt*4096 + rs*256 + grp*32 + fn*4 + fsel*2 + lng);
   endfunction

   task automatic model(bit v0, logic [15:0] h0, bit v1, logic [15:0] h1);
      int n;
      e_long  = h0 % 2;
      e_form  = e_long*2 + (h0/2) % 2;
      e_func  = (h0/4) % 8;
      e_group = (h0/32) % 4;
      e_rs    = (h0/256) % 16;
      e_rt    = h0 / 4096;
      e_valid = (v0 && (e_long == 0 || v1)) ? 1 : 0;
      e_rd    = e_rt;
      e_use   = 0;
      e_imm   = 0;
      case (e_form)
         1: begin
            n = (e_rs >= 8) ? e_rs - 16 : e_rs;
            e_use = 1;
            e_imm = (n < 0) ? n + 65536 : n;
         end
         2: begin e_use = 1; e_imm = h1; end
         3: e_rd = h1 / 4096;
         default: ;
      endcase
   endtask

   task automatic compare();
      chk("R9 valid", o_valid, e_valid);
      if (e_valid != 0) begin
         chk("R2 long", o_long, e_long);
         chk("R3 form", o_form, e_form);
         chk("R4 group", o_group, e_group);
         chk("R4 func", o_func, e_func);
         chk("R5 rs", o_rs, e_rs);
         chk("R5 rt", o_rt, e_rt);
         chk("R10 rd", o_rd, e_rd);
         chk("R10 use_imm", o_use_imm, e_use);
         case (e_form)
            1: chk("R6 imm4", o_imm, e_imm);
            2: chk("R7 imm16", o_imm, e_imm);
            3: chk("R8 imm zero", o_imm, e_imm);
            default: chk("R5 imm zero", o_imm, e_imm);
         endcase
      end
   endtask

   task automatic step(bit v0, logic [15:0] h0, bit v1, logic [15:0] h1);
      @(negedge clk);
      compare();
      hw0_v = v0; hw0 = h0; hw1_v = v1; hw1 = h1;
      model(v0, h0, v1, h1);
   endtask

   initial begin
      hw0 = mk(5, 9, 3, 7, 1, 1); hw0_v = 1'b1;
      repeat (3) @(negedge clk);
      // R1: outputs held at zero under reset
      chk("R1 valid", o_valid, 0);
      chk("R1 fields", {o_long, o_form, o_group, o_func, o_rs, o_rt, o_rd, o_use_imm}, 0);
      chk("R1 imm", o_imm, 0);
      hw0_v = 1'b0;
      model(0, '0, 0, '0);
      rst_n = 1'b1;

      // R5 short reg-reg
      step(1, mk(3, 12, 1, 5, 0, 0), 0, 16'h0);
      // R6 short imm corners: -8, +7, -1, 0
      step(1, mk(2, 8, 0, 0, 1, 0), 0, 16'h0);
      step(1, mk(15, 7, 2, 1, 1, 0), 0, 16'h0);
      step(1, mk(1, 15, 3, 6, 1, 0), 1, 16'hFFFF);
      step(1, mk(0, 0, 0, 0, 1, 0), 0, 16'h0);
      // R7 long reg-reg-imm16
      step(1, mk(4, 6, 1, 2, 0, 1), 1, 16'h8000);
      step(1, mk(9, 1, 2, 3, 0, 1), 1, 16'h7FFF);
      // R8 three-register with junk low bits
      step(1, mk(7, 11, 3, 4, 1, 1), 1, 16'hAFFF);
      step(1, mk(7, 11, 3, 4, 1, 1), 1, 16'hA000);
      // R9 long without second halfword, idle, short ignoring hw1_valid
      step(1, mk(6, 2, 0, 1, 1, 1), 0, 16'h1234);
      step(1, mk(6, 2, 0, 1, 0, 1), 0, 16'h1234);
      step(0, mk(1, 1, 1, 1, 0, 0), 1, 16'h0);
      step(1, mk(5, 5, 2, 2, 0, 0), 1, 16'h5555);

      for (int i = 0; i < 400; i++)
         step(($urandom % 8) != 0, 16'($urandom), ($urandom % 4) != 0, 16'($urandom));

      step(0, '0, 0, '0);
      step(0, '0, 0, '0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule